// File: doc/BRIEF.md
# Flash Flag Status Register Controller

This block holds the flag status byte of a serial NOR flash device's program/erase controller. A command decoder gives it start requests for program and erase. The program/erase engine gives it single-cycle event pulses: completion, verify failure, protection violation, and a detection that a pattern tried to turn a 0 back into a 1. The decoder also passes on suspend, resume and clear-flags requests. The block tracks what the controller is doing in a small state machine and drives the byte returned by a status read.

The two error flags are sticky. Only the clear-flags request resets them. While an error flag is set, the block refuses a new operation of the same type, so that command appears to fail. The decoder reads the two blocking outputs to report this. The 1-over-0 detection counts as a program error only when the high-voltage supply qualifier is asserted and the pattern length in bits is a non-zero multiple of 64. In all other cases the block leaves the flag unchanged.

States: `ST_IDLE` (ready), `ST_PROG` (program running), `ST_ERASE` (erase running), `ST_SUSP` (erase suspended, controller ready) and `ST_PROG_SUSP` (program running inside an erase suspend). Transitions:
- IDLE→ERASE on an erase start when the erase flag is clear. This has priority over a program start in the same cycle.
- IDLE→PROG on a program start when the program flag is clear.
- PROG→IDLE on done.
- ERASE→IDLE on done. Done wins over a suspend in the same cycle.
- ERASE→SUSP on suspend.
- SUSP→ERASE on resume. Resume wins over a program start in the same cycle.
- SUSP→PROG_SUSP on a program start when the program flag is clear.
- PROG_SUSP→SUSP on done.

Top module: `fsr_ctrl`

## Requirements
- R1: After reset the status byte reads 8'h80. Bits 3..0 always read 0.
- R2: Bit 7 (ready) goes low on the clock edge that accepts a start request. It goes high on the edge that takes the done pulse. If erase and program start together in the ready idle state, the erase is taken.
- R3: An erase start while bit 5 is set, or a program start while bit 4 is set, is refused. Bit 7 stays high and the state is unchanged.
- R4: A suspend during an erase sets bit 6 and bit 7 on the next edge. A suspend at any other time has no effect. A done in the same cycle as a suspend ends the erase instead.
- R5: A resume while suspended clears bit 6 and bit 7 on the next edge, and the erase continues.
- R6: While suspended, a program start is accepted: bit 7 goes low and bit 6 stays high. Its done returns the block to the suspended state. An erase start while suspended is ignored.
- R7: An erase verify failure or a protection error during an erase sets bit 5 on the next edge.
- R8: A program verify failure or a protection error during a program (including a program inside a suspend) sets bit 4 on the next edge.
- R9: A 1-over-0 detection during a program sets bit 4 only if the high-voltage qualifier is high and the pattern length is a non-zero multiple of 64 bits. Otherwise bit 4 is unchanged.
- R10: Bits 5 and 4 stay set until a clear-flags request. A clear resets both on the next edge. A set event in the same cycle as a clear wins for its own bit.
- R11: Error events that arrive when no operation of the matching type is running leave bits 5 and 4 unchanged.
- R12: `erase_block` always equals bit 5 and `prog_block` always equals bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_prog | input | 1 | Decoded program command request |
| start_erase | input | 1 | Decoded erase command request (sector, subsector or bulk) |
| op_done | input | 1 | Engine completion pulse |
| erase_fail | input | 1 | Erase still failed verify after the maximum pulse count |
| prog_fail | input | 1 | Program still failed verify after the maximum pulse count |
| prot_err | input | 1 | Running operation addressed a protected region |
| suspend_req | input | 1 | Suspend request |
| resume_req | input | 1 | Resume request |
| one_over_zero | input | 1 | Pattern attempted to program 1 over 0 |
| pattern_len | input | LEN_W | Length of the program pattern in bits |
| hv_present | input | 1 | High-voltage supply qualifier |
| clear_flags | input | 1 | Decoded clear-flags command |
| fsr | output | 8 | Status byte: [7] ready, [6] erase suspended, [5] erase error, [4] program error, [3:0] zero |
| erase_block | output | 1 | New erase would fail (bit 5 set) |
| prog_block | output | 1 | New program would fail (bit 4 set) |

## Verification
The assertions assume that every input is a clean single-cycle pulse sampled on the rising edge. They also assume that the engine raises error events only while it is running an operation, although the design itself ignores events that come at other times. The bench drives all inputs on the falling edge and returns pulses to zero after one cycle. It also leaves the length and voltage qualifier stable around each 1-over-0 pulse. A randomized phase allows overlapping pulses, including clear together with an error and done together with a suspend. This covers the same-cycle priorities that the properties state with explicit guards.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROG      = 3'd1,
        ST_ERASE     = 3'd2,
        ST_SUSP      = 3'd3,
        ST_PROG_SUSP = 3'd4
    } op_state_t;

    localparam int FLAG_ERASE = 0;
    localparam int FLAG_PROG  = 1;
    localparam int NUM_FLAGS  = 2;

    localparam int BIT_READY  = 7;
    localparam int BIT_SUSP   = 6;
    localparam int BIT_EERR   = 5;
    localparam int BIT_PERR   = 4;
    localparam int REG_W      = 8;

endpackage

// File: rtl/fsr_op_fsm.sv
module fsr_op_fsm
    import fsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_prog,
    input  logic      start_erase,
    input  logic      op_done,
    input  logic      suspend_req,
    input  logic      resume_req,
    input  logic      erase_blk,
    input  logic      prog_blk,
    output op_state_t state,
    output logic      ready,
    output logic      suspended
);

    op_state_t state_q;
    op_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_erase && !erase_blk) begin
                    state_d = ST_ERASE;
                end else if (start_prog && !prog_blk) begin
                    state_d = ST_PROG;
                end
            end
            ST_PROG: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                end else if (suspend_req) begin
                    state_d = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (resume_req) begin
                    state_d = ST_ERASE;
                end else if (start_prog && !prog_blk) begin
                    state_d = ST_PROG_SUSP;
                end
            end
            ST_PROG_SUSP: begin
                if (op_done) begin
                    state_d = ST_SUSP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        suspended = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready = 1'b1;
            ST_PROG:      ready = 1'b0;
            ST_ERASE:     ready = 1'b0;
            ST_SUSP: begin
                ready     = 1'b1;
                suspended = 1'b1;
            end
            ST_PROG_SUSP: suspended = 1'b1;
            default:      ready = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/fsr_err_qual.sv
module fsr_err_qual
    import fsr_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int CHUNK_BITS = 64
) (
    input  op_state_t            state,
    input  logic                 erase_fail,
    input  logic                 prog_fail,
    input  logic                 prot_err,
    input  logic                 one_over_zero,
    input  logic [LEN_W-1:0]     pattern_len,
    input  logic                 hv_present,
    output logic [NUM_FLAGS-1:0] set_vec
);

    localparam int CHUNK_LOG = $clog2(CHUNK_BITS);

    logic in_erase;
    logic in_prog;
    logic len_whole;
    logic ovz_hit;

    always_comb begin
        in_erase  = (state == ST_ERASE);
        in_prog   = (state == ST_PROG) || (state == ST_PROG_SUSP);
        len_whole = (pattern_len[CHUNK_LOG-1:0] == '0) &&
                    (pattern_len[LEN_W-1:CHUNK_LOG] != '0);
        ovz_hit   = one_over_zero && hv_present && len_whole;

        set_vec             = '0;
        set_vec[FLAG_ERASE] = in_erase && (erase_fail || prot_err);
        set_vec[FLAG_PROG]  = in_prog  && (prog_fail || prot_err || ovz_hit);
    end

endmodule

// File: rtl/fsr_sticky_flag.sv
module fsr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (clr_i) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int CHUNK_BITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_prog,
    input  logic             start_erase,
    input  logic             op_done,
    input  logic             erase_fail,
    input  logic             prog_fail,
    input  logic             prot_err,
    input  logic             suspend_req,
    input  logic             resume_req,
    input  logic             one_over_zero,
    input  logic [LEN_W-1:0] pattern_len,
    input  logic             hv_present,
    input  logic             clear_flags,
    output logic [7:0]       fsr,
    output logic             erase_block,
    output logic             prog_block
);

    op_state_t            state_q;
    logic                 ready;
    logic                 suspended;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flag_q;

    fsr_op_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .op_done     (op_done),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .erase_blk   (flag_q[FLAG_ERASE]),
        .prog_blk    (flag_q[FLAG_PROG]),
        .state       (state_q),
        .ready       (ready),
        .suspended   (suspended)
    );

    fsr_err_qual #(
        .LEN_W      (LEN_W),
        .CHUNK_BITS (CHUNK_BITS)
    ) u_qual (
        .state         (state_q),
        .erase_fail    (erase_fail),
        .prog_fail     (prog_fail),
        .prot_err      (prot_err),
        .one_over_zero (one_over_zero),
        .pattern_len   (pattern_len),
        .hv_present    (hv_present),
        .set_vec       (set_vec)
    );

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        fsr_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[gi]),
            .clr_i (clear_flags),
            .q     (flag_q[gi])
        );
    end

    always_comb begin
        fsr            = '0;
        fsr[BIT_READY] = ready;
        fsr[BIT_SUSP]  = suspended;
        fsr[BIT_EERR]  = flag_q[FLAG_ERASE];
        fsr[BIT_PERR]  = flag_q[FLAG_PROG];
    end

    assign erase_block = flag_q[FLAG_ERASE];
    assign prog_block  = flag_q[FLAG_PROG];

endmodule

// File: rtl/fsr_ctrl_chk.sv
module fsr_ctrl_chk
    import fsr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      start_prog,
    input logic      start_erase,
    input logic      op_done,
    input logic      erase_fail,
    input logic      prog_fail,
    input logic      prot_err,
    input logic      suspend_req,
    input logic      resume_req,
    input logic      one_over_zero,
    input logic      hv_present,
    input logic      clear_flags,
    input logic [7:0] fsr,
    input logic      erase_block,
    input logic      prog_block,
    input op_state_t st
);

    p_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fsr[3:0] == 4'h0);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start_erase && !fsr[5]) |=> !fsr[7]);

    p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PROG || st == ST_ERASE) && op_done) |=> fsr[7] && !fsr[6]);

    p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start_erase && fsr[5] && !start_prog) |=> fsr[7]);

    p_suspend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && suspend_req && !op_done) |=> fsr[6] && fsr[7]);

    p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && resume_req) |=> !fsr[6] && !fsr[7]);

    p_prog_in_susp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG_SUSP) |-> fsr[6] && !fsr[7]);

    p_erase_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && (erase_fail || prot_err)) |=> fsr[5]);

    p_prog_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PROG || st == ST_PROG_SUSP) && prog_fail) |=> fsr[4]);

    p_no_hv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hv_present && one_over_zero && !prog_fail && !prot_err && !fsr[4]) |=> !fsr[4]);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsr[5] && !clear_flags) |=> fsr[5]);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_flags && !erase_fail && !prog_fail && !prot_err && !one_over_zero)
        |=> !fsr[5] && !fsr[4]);

    p_idle_events_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !fsr[4] && !fsr[5]) |=> !fsr[4] && !fsr[5]);

    p_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        erase_block == fsr[5] && prog_block == fsr[4]);

endmodule

bind fsr_ctrl fsr_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_prog    (start_prog),
    .start_erase   (start_erase),
    .op_done       (op_done),
    .erase_fail    (erase_fail),
    .prog_fail     (prog_fail),
    .prot_err      (prot_err),
    .suspend_req   (suspend_req),
    .resume_req    (resume_req),
    .one_over_zero (one_over_zero),
    .hv_present    (hv_present),
    .clear_flags   (clear_flags),
    .fsr           (fsr),
    .erase_block   (erase_block),
    .prog_block    (prog_block),
    .st            (state_q)
);

// File: tb/fsr_ctrl_tb.sv
module fsr_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam int LEN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_prog = 0, start_erase = 0, op_done = 0;
    logic             erase_fail = 0, prog_fail = 0, prot_err = 0;
    logic             suspend_req = 0, resume_req = 0, one_over_zero = 0;
    logic [LEN_W-1:0] pattern_len = '0;
    logic             hv_present = 0, clear_flags = 0;
    logic [7:0]       fsr;
    logic             erase_block, prog_block;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    // reference model: 0 idle, 1 program, 2 erase, 3 suspended, 4 program in suspend
    int mode = 0;
    bit m_ef = 0;
    bit m_pf = 0;

    always #(CLK_P/2) clk = ~clk;

    fsr_ctrl #(.LEN_W(LEN_W), .CHUNK_BITS(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
        .op_done(op_done), .erase_fail(erase_fail), .prog_fail(prog_fail),
        .prot_err(prot_err), .suspend_req(suspend_req), .resume_req(resume_req),
        .one_over_zero(one_over_zero), .pattern_len(pattern_len),
        .hv_present(hv_present), .clear_flags(clear_flags), .fsr(fsr),
        .erase_block(erase_block), .prog_block(prog_block)
    );

    function automatic logic [7:0] model_fsr();
        logic [7:0] v;
        v = 8'h00;
        v[7] = (mode == 0) || (mode == 3);
        v[6] = (mode == 3) || (mode == 4);
        v[5] = m_ef;
        v[4] = m_pf;
        return v;
    endfunction

    task automatic model_update();
        bit set_e, set_p, ovz_ok;
        int nmode;
        ovz_ok = one_over_zero && hv_present && (pattern_len % 64 == 0) && (pattern_len != 0);
        set_e = (mode == 2) && (erase_fail || prot_err);
        set_p = (mode == 1 || mode == 4) && (prog_fail || prot_err || ovz_ok);
        nmode = mode;
        if (mode == 0) begin
            if (start_erase && !m_ef) nmode = 2;
            else if (start_prog && !m_pf) nmode = 1;
        end else if (mode == 1) begin
            if (op_done) nmode = 0;
        end else if (mode == 2) begin
            if (op_done) nmode = 0;
            else if (suspend_req) nmode = 3;
        end else if (mode == 3) begin
            if (resume_req) nmode = 2;
            else if (start_prog && !m_pf) nmode = 4;
        end else begin
            if (op_done) nmode = 3;
        end
        mode = nmode;
        if (set_e) m_ef = 1; else if (clear_flags) m_ef = 0;
        if (set_p) m_pf = 1; else if (clear_flags) m_pf = 0;
    endtask

    task automatic compare(input string tag);
        logic [7:0] exp_v;
        exp_v = model_fsr();
        checks++;
        if (fsr !== exp_v) begin
            errors++;
            $display("FAIL %s: fsr actual=%h expected=%h", tag, fsr, exp_v);
        end
        checks++;
        if (erase_block !== exp_v[5] || prog_block !== exp_v[4]) begin
            errors++;
            $display("FAIL R12 (%s): blocks actual=%b%b expected=%b%b", tag,
                     erase_block, prog_block, exp_v[5], exp_v[4]);
        end
    endtask

    task automatic clear_pulses();
        start_prog = 0; start_erase = 0; op_done = 0; erase_fail = 0;
        prog_fail = 0; prot_err = 0; suspend_req = 0; resume_req = 0;
        one_over_zero = 0; clear_flags = 0;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
        clear_pulses();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        step("R1 idle");

        // program start and done
        start_prog = 1; step("R2 program start");
        step("R2 busy hold");
        op_done = 1; step("R2 program done");
        // both starts: erase taken
        start_prog = 1; start_erase = 1; step("R2 erase priority");
        op_done = 1; step("R2 erase done");

        // erase failure, then refused erase
        start_erase = 1; step("R2 erase start");
        erase_fail = 1; step("R7 erase fail");
        op_done = 1; step("R2 done after fail");
        start_erase = 1; step("R3 erase refused");
        step("R10 sticky");
        clear_flags = 1; step("R10 clear");
        start_erase = 1; step("R3 erase accepted after clear");
        prot_err = 1; clear_flags = 1; step("R10 set beats clear");
        op_done = 1; step("R2 done");
        clear_flags = 1; step("R10 clear again");

        // program errors
        start_prog = 1; step("R2 program start");
        prot_err = 1; step("R8 protection in program");
        op_done = 1; step("R2 done");
        start_prog = 1; step("R3 program refused");
        clear_flags = 1; step("R10 clear");

        // 1-over-0 qualification
        start_prog = 1; step("R2 program start");
        hv_present = 0; pattern_len = 64; one_over_zero = 1; step("R9 no high voltage");
        hv_present = 1; pattern_len = 100; one_over_zero = 1; step("R9 odd length");
        pattern_len = 0; one_over_zero = 1; step("R9 zero length");
        pattern_len = 128; one_over_zero = 1; step("R9 whole length sets");
        op_done = 1; step("R2 done");
        clear_flags = 1; step("R10 clear");

        // events outside operations
        erase_fail = 1; prog_fail = 1; prot_err = 1; step("R11 idle events");
        hv_present = 1; pattern_len = 64; one_over_zero = 1; step("R11 idle 1-over-0");
        start_prog = 1; step("R2 program start");
        erase_fail = 1; step("R11 erase fail during program");
        suspend_req = 1; step("R4 suspend during program ignored");
        op_done = 1; step("R2 done");
        start_erase = 1; step("R2 erase start");
        prog_fail = 1; step("R11 program fail during erase");

        // suspend / resume
        suspend_req = 1; step("R4 suspend");
        erase_fail = 1; step("R11 erase fail while suspended");
        start_erase = 1; step("R6 erase start ignored in suspend");
        start_prog = 1; step("R6 program in suspend");
        prog_fail = 1; step("R8 fail in suspended program");
        op_done = 1; step("R6 back to suspend");
        clear_flags = 1; step("R10 clear");
        resume_req = 1; start_prog = 1; step("R5 resume");
        suspend_req = 1; op_done = 1; step("R4 done beats suspend");

        // randomized phase
        for (int i = 0; i < 2000; i++) begin
            start_prog    = ($urandom % 4) == 0;
            start_erase   = ($urandom % 5) == 0;
            op_done       = ($urandom % 4) == 0;
            erase_fail    = ($urandom % 12) == 0;
            prog_fail     = ($urandom % 12) == 0;
            prot_err      = ($urandom % 14) == 0;
            suspend_req   = ($urandom % 5) == 0;
            resume_req    = ($urandom % 5) == 0;
            one_over_zero = ($urandom % 6) == 0;
            pattern_len   = ($urandom % 2) ? LEN_W'(64 * ($urandom % 8)) : LEN_W'($urandom);
            hv_present    = ($urandom % 2) == 0;
            clear_flags   = ($urandom % 7) == 0;
            step("R2/R4/R5/R6/R7/R8/R9/R10 mixed");
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule